// File: doc/BRIEF.md
# Sector Erase Batching Window

This block gathers sector erase requests into one batch before the internal erase begins. The command decoder upstream marks each complete command with a one-cycle strobe. It also says whether the command is a sector erase and which sector it names. The first sector erase request marks its sector as pending and opens a collection window. Each further sector erase request inside the window adds its sector to the pending set and restarts the window. When a full window passes with no command, the block issues a one-cycle start pulse and raises the erase-timer status bit. The pending sector mask is held steady for the erase engine until that engine reports completion.

Status polling can start as soon as the first request is taken. A busy flag goes high at that point, before the window has closed. Once the status bit is high, the erase is committed and later sector erase requests are dropped. A command of any other type inside the window cancels the batch and empties the pending set.

Top module: `serase_collect`

## Requirements
- R1: After reset, `pend_mask` is all zeros and `erase_start`, `timer_status` and `busy` are 0.
- R2: In idle, a strobe with `cmd_is_erase`=1 sets bit `cmd_sector` of `pend_mask` (bit i stands for sector i) from the next cycle on. It raises `busy` and leaves `timer_status` at 0.
- R3: While the window is open (`busy`=1, `timer_status`=0), each sector erase strobe ORs its sector bit into `pend_mask` and restarts the window count.
- R4: With no strobe, `erase_start` goes high for exactly one cycle, WIN_CYC clock edges after the edge that took the last accepted request. `timer_status` rises on that same edge.
- R5: While `timer_status` is 1 and `erase_done` is 0, `timer_status`, `busy` and `pend_mask` stay unchanged.
- R6: A sector erase strobe while `timer_status` is 1 is rejected and leaves `pend_mask` unchanged.
- R7: A strobe with `cmd_is_erase`=0 while the window is open clears `pend_mask` and `busy` from the next cycle, and no `erase_start` follows.
- R8: `erase_done` while `timer_status` is 1 clears `pend_mask`, `timer_status` and `busy` from the next cycle.
- R9: A strobe with `cmd_is_erase`=0 in idle or during the erase has no effect. `erase_done` outside the erase phase also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | One-cycle strobe for a decoded complete command |
| cmd_is_erase | input | 1 | The strobed command is a sector erase |
| cmd_sector | input | SEC_W | Sector named by the command |
| erase_done | input | 1 | Erase engine reports completion |
| pend_mask | output | NSEC | Pending sector set, one bit per sector |
| erase_start | output | 1 | One-cycle pulse that starts the erase |
| timer_status | output | 1 | 0 while requests are accepted, 1 once the erase has begun |
| busy | output | 1 | A batch is open or an erase is in progress |

## Verification
Directed runs cover four cases: a single request left to expire, a second request landing late in the window, a window cancelled by another command, and requests and completions arriving during the erase. These show whether the window restarts or runs out on its original count, and whether a cancel or a late request can leak into the mask. A seeded random phase follows, with sparse strobes, mostly sector erases, and occasional completion reports. It lands requests on the expiry edge itself and mixes commands with completions in the same cycle. Both cases show whether the command wins over expiry and whether completion wins during the erase.

// File: rtl/serase_pkg.sv
package serase_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } sew_state_e;
endpackage

// File: rtl/serase_timer.sv
module serase_timer #(
  parameter int WIN_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
  localparam logic [CW-1:0] LOAD_V = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (run && (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load)        cnt_d = LOAD_V;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R4: the count falls by one per running cycle
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R3: a reload opens a full window
  p_reload_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired || (WIN_CYC == 1));
endmodule

// File: rtl/serase_mask.sv
module serase_mask #(
  parameter int NSEC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    add,
  input  logic [$clog2(NSEC)-1:0] sector,
  input  logic                    clr,
  output logic [NSEC-1:0]         mask
);
  localparam int SEC_W = $clog2(NSEC);

  logic [NSEC-1:0] set_vec, mask_d, mask_q;
  logic            mask_en;

  for (genvar i = 0; i < NSEC; i++) begin : g_bit
    assign set_vec[i] = add && (sector == SEC_W'(i));
  end

  always_comb begin
    mask_en = add || clr;
    mask_d  = clr ? '0 : (mask_q | set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask = mask_q;

  // R8: a clear empties the set
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0));
  // R3: without a clear no bit is ever lost
  p_grow_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((mask & $past(mask)) == $past(mask)));
endmodule

// File: rtl/serase_collect.sv
module serase_collect
  import serase_pkg::*;
#(
  parameter int NSEC    = 16,
  parameter int WIN_CYC = 8,
  localparam int SEC_W  = $clog2(NSEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic             cmd_is_erase,
  input  logic [SEC_W-1:0] cmd_sector,
  input  logic             erase_done,
  output logic [NSEC-1:0]  pend_mask,
  output logic             erase_start,
  output logic             timer_status,
  output logic             busy
);
  sew_state_e st_q, st_d;
  logic accept, abort, fire, clr, expired;
  logic start_q;

  always_comb begin
    accept = cmd_vld && cmd_is_erase && (st_q != ST_ERASE);
    abort  = cmd_vld && !cmd_is_erase && (st_q == ST_WINDOW);
    fire   = (st_q == ST_WINDOW) && !cmd_vld && expired;
    clr    = abort || ((st_q == ST_ERASE) && erase_done);
    st_d   = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = ST_WINDOW;
      ST_WINDOW: begin
        if (abort)     st_d = ST_IDLE;
        else if (fire) st_d = ST_ERASE;
      end
      ST_ERASE:  if (erase_done) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= fire;
    end
  end

  serase_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .run     (st_q == ST_WINDOW),
    .expired (expired)
  );

  serase_mask #(.NSEC(NSEC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .add    (accept),
    .sector (cmd_sector),
    .clr    (clr),
    .mask   (pend_mask)
  );

  assign erase_start  = start_q;
  assign timer_status = (st_q == ST_ERASE);
  assign busy         = (st_q != ST_IDLE);

  // R2: first request marks its sector and opens the window
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_vld && cmd_is_erase) |=>
      (busy && !timer_status && pend_mask[$past(cmd_sector)]));
  // R4: start is a single-cycle pulse
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
  // R4: status rises only together with the start pulse
  p_status_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_status) |-> erase_start);
  // R4: an erase never starts with an empty set
  p_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (pend_mask != '0));
  // R5 and R6: the set is frozen during the erase
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_status && !erase_done) |=> (timer_status && $stable(pend_mask)));
  // R7: a foreign command cancels the batch
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !timer_status && cmd_vld && !cmd_is_erase) |=>
      (!busy && pend_mask == '0));
endmodule

// File: tb/serase_collect_bench.sv
`timescale 1ns/1ps
module serase_collect_bench;
  localparam int NSEC    = 16;
  localparam int WIN_CYC = 8;
  localparam int SEC_W   = $clog2(NSEC);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_vld, cmd_is_erase, erase_done;
  logic [SEC_W-1:0] cmd_sector;
  logic [NSEC-1:0]  pend_mask;
  logic             erase_start, timer_status, busy;

  always #2.5 clk = ~clk;

  serase_collect #(.NSEC(NSEC), .WIN_CYC(WIN_CYC)) u_serase_collect (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_is_erase(cmd_is_erase),
    .cmd_sector(cmd_sector), .erase_done(erase_done), .pend_mask(pend_mask),
    .erase_start(erase_start), .timer_status(timer_status), .busy(busy)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference: 0 idle, 1 window, 2 erasing; age = edges since last accepted request
  int              m_st = 0;
  int              m_age = 0;
  logic [NSEC-1:0] m_mask = '0;
  logic            m_start = 1'b0;

  function automatic void model_edge(logic v, logic e, logic [SEC_W-1:0] s, logic d);
    m_start = 1'b0;
    case (m_st)
      0: if (v && e) begin m_mask = NSEC'(1) << s; m_age = 0; m_st = 1; end
      1: begin
        if (v && e) begin m_mask = m_mask | (NSEC'(1) << s); m_age = 0; end
        else if (v) begin m_mask = '0; m_st = 0; end
        else begin
          m_age = m_age + 1;
          if (m_age == WIN_CYC) begin m_st = 2; m_start = 1'b1; end
        end
      end
      default: if (d) begin m_mask = '0; m_st = 0; end
    endcase
  endfunction

  task automatic compare(string tag);
    logic exp_stat, exp_busy;
    exp_stat = (m_st == 2);
    exp_busy = (m_st != 0);
    n_vec++;
    if (pend_mask !== m_mask || erase_start !== m_start ||
        timer_status !== exp_stat || busy !== exp_busy) begin
      n_bad++;
      $display("FAIL %s: got mask=%h start=%b status=%b busy=%b, expected mask=%h start=%b status=%b busy=%b",
               tag, pend_mask, erase_start, timer_status, busy,
               m_mask, m_start, exp_stat, exp_busy);
    end
  endtask

  task automatic step(string tag, logic v, logic e, logic [SEC_W-1:0] s, logic d);
    @(negedge clk);
    cmd_vld = v; cmd_is_erase = e; cmd_sector = s; erase_done = d;
    @(posedge clk);
    model_edge(v, e, s, d);
    #1;
    compare(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cmd_vld = 0; cmd_is_erase = 0; cmd_sector = '0; erase_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 compare("R1");
    idle("R1", 2);
    // first request, sector 3
    step("R2", 1, 1, 4'd3, 0);
    idle("R4", 5);
    // late second request restarts the window
    step("R3", 1, 1, 4'd9, 0);
    idle("R3", WIN_CYC - 1);
    idle("R4", 2);
    idle("R5", 3);
    // rejected request and foreign command during erase
    step("R6", 1, 1, 4'd1, 0);
    step("R9", 1, 0, 4'd5, 0);
    idle("R5", 1);
    step("R8", 0, 0, '0, 1);
    // completion and foreign command in idle
    step("R9", 0, 0, '0, 1);
    step("R9", 1, 0, 4'd7, 0);
    // cancelled batch
    step("R2", 1, 1, 4'd2, 0);
    idle("R7", 3);
    step("R7", 1, 0, 4'd0, 0);
    idle("R7", WIN_CYC + 2);
    // request on the expiry edge
    step("R2", 1, 1, 4'd15, 0);
    idle("R4", WIN_CYC - 1);
    step("R3", 1, 1, 4'd0, 0);
    idle("R4", WIN_CYC + 1);
    step("R8", 1, 1, 4'd4, 1);
    idle("R1", 1);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic v, e, d;
      v = ($urandom % 5) == 0;
      e = ($urandom % 6) != 0;
      d = ($urandom % 12) == 0;
      step("R4", v, e, SEC_W'($urandom), d);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule